// File: doc/BRIEF.md
# Memory Controller Performance Counter Bank

This block sits beside a DRAM controller and turns that controller's performance event pulses into counts. It has four 32-bit counters. Counter 0 is a time base: once enabled it advances on every clock. When it reaches all ones and would wrap, it freezes the whole bank and raises an interrupt. Counters 1 to 3 each pick one bit of a wide event vector through their own select code. These counters wrap silently on overflow. Two select codes stand for ID-filtered reads and ID-filtered writes. For those two codes the event also needs a per-counter qualifier, which the filter logic outside this block computes.

Software uses a plain register port. It writes the select codes and sets the global run bit. It may preload or clear counters while the bank is stopped. After an expiry it reads the frozen values and writes one to the status bit to release the freeze, which also drops the interrupt. Reads are registered, so the returned count is a clean snapshot that stays put while the counters move on. There is no data stream here: every pin is a plain control or status pin, and the register port has no back-pressure. A read request is always answered on the next cycle.

Top module: `ddr_pmu_top`

## Requirements
- R1: After reset, every counter, every select code, the run bit and the frozen flag are zero; `irq` and `reg_rd_valid` are low and `reg_rd_data` is zero.
- R2: Register addresses are as follows. Address 0, bit 0 is the run bit (read/write). Address 1, bit 0 is the frozen flag. Addresses 2 to 5 hold the 8-bit select codes of counters 0 to 3. Addresses 8 to 11 hold counters 0 to 3. A read issued in cycle t returns its data with `reg_rd_valid` high in cycle t+1, and any other address reads as zero.
- R3: While running and not frozen, counter 0 grows by one on every clock, whatever its select code holds.
- R4: If counter 0 is all ones while running and not frozen, the next edge sets the frozen flag and `irq`, and counter 0 stays at all ones. From then on no counter changes except by a load.
- R5: While running and not frozen, counter k (1 to 3) with select code c below 128 gains one for each cycle in which `evt_pulse[c]` is high. It gains at most one per cycle, goes from all ones to zero, and neither freezes nor interrupts on that wrap.
- R6: For select codes 0x41 and 0x42, counter k counts only in cycles where both `evt_pulse[code]` and `id_match[k-1]` are high.
- R7: A select code of 128 or above counts nothing.
- R8: Writing address 1 with bit 0 set clears the frozen flag and `irq` at the next edge. Writing it with bit 0 clear changes nothing. If an expiry happens on the same edge, the expiry wins.
- R9: A write to a counter address while the run bit is clear loads that counter with the write data, so writing zero clears it. While the run bit is set, such a write is ignored.
- R10: `reg_rd_data` holds the value returned by the last read until the next read request, and a counter read returns the value the counter held in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | EVT_W | Single-cycle event pulses from the controller |
| id_match | input | NUM_CNT-1 | Bit k-1 is the ID filter qualifier for counter k |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Write address |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_en | input | 1 | Register read request |
| reg_rd_addr | input | ADDR_W | Read address |
| reg_rd_data | output | DATA_W | Registered read data |
| reg_rd_valid | output | 1 | High one cycle after a read request |
| irq | output | 1 | Expiry interrupt, high while frozen |

## Verification
Each counter change follows one edge after its cause. An event pulse, a load or a tick in cycle t shows in the counter from cycle t+1. A read placed in cycle t+1 reports that value in cycle t+2. The frozen flag and `irq` change on the edge that ends the cycle in which counter 0 is all ones or in which the clear write is presented. The bench drives inputs on the falling edge and steps a behavioural model on the rising edge with the same inputs. It compares `irq`, `reg_rd_valid` and `reg_rd_data` on every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/ddr_pmu_pkg.sv
package ddr_pmu_pkg;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_STAT = 1;
  localparam int unsigned ADDR_CFG0 = 2;
  localparam int unsigned ADDR_CNT0 = 8;
  localparam logic [7:0]  CODE_ID_RD = 8'h41;
  localparam logic [7:0]  CODE_ID_WR = 8'h42;
endpackage

// File: rtl/ddr_pmu_evsel.sv
module ddr_pmu_evsel #(
  parameter int EVT_W = 128,
  parameter int SEL_W = 8
) (
  input  logic [EVT_W-1:0] evt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             qual_i,
  output logic             hit_o
);
  import ddr_pmu_pkg::*;
  localparam int IDX_W = $clog2(EVT_W);

  logic             in_range;
  logic             filtered;
  logic [IDX_W-1:0] idx;

  always_comb begin
    in_range = (32'(sel_i) < EVT_W);
    idx      = IDX_W'(sel_i);
    filtered = (8'(sel_i) == CODE_ID_RD) || (8'(sel_i) == CODE_ID_WR);
    hit_o    = 1'b0;
    if (in_range) begin
      hit_o = evt_i[idx] && (!filtered || qual_i);
    end
  end
endmodule

// File: rtl/ddr_pmu_counter.sv
module ddr_pmu_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             max_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_o <= '0;
    else if (load_i) count_o <= load_val_i;
    else if (inc_i)  count_o <= count_o + 1'b1;
  end

  assign max_o = &count_o;

  // R5: an increment at all ones lands on zero
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && max_o) |=> (count_o == '0));

  // R9: a load takes the presented value
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_o == $past(load_val_i)));
endmodule

// File: rtl/ddr_pmu_regs.sv
module ddr_pmu_regs #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic                           rd_en_i,
  input  logic [ADDR_W-1:0]              rd_addr_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]  count_i,
  input  logic                           expire_i,
  output logic                           run_en_o,
  output logic                           frozen_o,
  output logic [NUM_CNT-1:0][SEL_W-1:0]  sel_o,
  output logic [NUM_CNT-1:0]             load_o,
  output logic [CNT_W-1:0]               load_val_o,
  output logic [DATA_W-1:0]              rd_data_o,
  output logic                           rd_valid_o
);
  import ddr_pmu_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  logic                clr_frz;
  logic [DATA_W-1:0]   rd_mux;

  assign clr_frz    = wr_en_i && (wr_addr_i == A_STAT) && wr_data_i[0];
  assign load_val_o = wr_data_i[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en_o <= 1'b0;
      frozen_o <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == A_CTRL) run_en_o <= wr_data_i[0];
      if (expire_i)     frozen_o <= 1'b1;
      else if (clr_frz) frozen_o <= 1'b0;
    end
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_slot
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(ADDR_CFG0 + k);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(ADDR_CNT0 + k);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_o[k] <= '0;
      else if (wr_en_i && wr_addr_i == A_CFG) sel_o[k] <= wr_data_i[SEL_W-1:0];
    end

    assign load_o[k] = wr_en_i && !run_en_o && (wr_addr_i == A_CNT);
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr_i == A_CTRL) rd_mux[0] = run_en_o;
    if (rd_addr_i == A_STAT) rd_mux[0] = frozen_o;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (rd_addr_i == ADDR_W'(ADDR_CFG0 + k)) rd_mux = DATA_W'(sel_o[k]);
      if (rd_addr_i == ADDR_W'(ADDR_CNT0 + k)) rd_mux = DATA_W'(count_i[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end

  // R4: expiry sets the frozen flag
  p_expire_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> frozen_o);

  // R8: a clear write without a coincident expiry releases the freeze
  p_clear_frz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_frz && !expire_i) |=> !frozen_o);

  // R2: every read is answered one cycle later
  p_rd_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);

  // R10: returned data holds between reads
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/ddr_pmu_top.sv
module ddr_pmu_top #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int EVT_W   = 128,
  parameter int SEL_W   = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EVT_W-1:0]   evt_pulse,
  input  logic [NUM_CNT-2:0] id_match,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_wr_addr,
  input  logic [DATA_W-1:0]  reg_wr_data,
  input  logic               reg_rd_en,
  input  logic [ADDR_W-1:0]  reg_rd_addr,
  output logic [DATA_W-1:0]  reg_rd_data,
  output logic               reg_rd_valid,
  output logic               irq
);
  logic                          run_en;
  logic                          frozen;
  logic                          running;
  logic                          expire;
  logic [NUM_CNT-1:0][CNT_W-1:0] count;
  logic [NUM_CNT-1:0][SEL_W-1:0] sel;
  logic [NUM_CNT-1:0]            load;
  logic [NUM_CNT-1:0]            inc;
  logic [NUM_CNT-1:0]            at_max;
  logic [CNT_W-1:0]              load_val;

  assign running = run_en && !frozen;
  assign expire  = running && at_max[0];
  assign irq     = frozen;

  ddr_pmu_regs #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .SEL_W(SEL_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(reg_wr_en), .wr_addr_i(reg_wr_addr), .wr_data_i(reg_wr_data),
    .rd_en_i(reg_rd_en), .rd_addr_i(reg_rd_addr),
    .count_i(count), .expire_i(expire),
    .run_en_o(run_en), .frozen_o(frozen), .sel_o(sel),
    .load_o(load), .load_val_o(load_val),
    .rd_data_o(reg_rd_data), .rd_valid_o(reg_rd_valid)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    if (k == 0) begin : g_time
      assign inc[k] = running && !at_max[k];
    end else begin : g_event
      logic hit;
      ddr_pmu_evsel #(.EVT_W(EVT_W), .SEL_W(SEL_W)) u_sel (
        .evt_i(evt_pulse), .sel_i(sel[k]), .qual_i(id_match[k-1]), .hit_o(hit)
      );
      assign inc[k] = running && hit;

      // R7: a select code beyond the event vector leaves the counter alone
      p_unknown_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((32'(sel[k]) >= EVT_W) && !load[k]) |=> $stable(count[k]));
    end

    ddr_pmu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .load_i(load[k]), .load_val_i(load_val), .inc_i(inc[k]),
      .count_o(count[k]), .max_o(at_max[k])
    );

    // R4: a frozen bank holds every counter unless software loads it
    p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && !load[k]) |=> $stable(count[k]));
  end

  // R3: the time base advances one per cycle while running below all ones
  p_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !at_max[0] && !load[0]) |=> (count[0] == $past(count[0]) + 1'b1));

  // R4: at expiry counter 0 stays at all ones
  p_expire_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load[0]) |=> (irq && at_max[0]));
endmodule

// File: tb/ddr_pmu_top_bench.sv
module ddr_pmu_top_bench;
  localparam int EVT_W = 128;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [EVT_W-1:0]  evt_pulse = '0;
  logic [2:0]        id_match = '0;
  logic              reg_wr_en = 1'b0;
  logic [3:0]        reg_wr_addr = '0;
  logic [31:0]       reg_wr_data = '0;
  logic              reg_rd_en = 1'b0;
  logic [3:0]        reg_rd_addr = '0;
  logic [31:0]       reg_rd_data;
  logic              reg_rd_valid;
  logic              irq;

  ddr_pmu_top u_ddr_pmu_top (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .id_match(id_match),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data), .reg_rd_valid(reg_rd_valid), .irq(irq)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  string tag    = "R1";

  // behavioural reference state
  bit        m_run, m_frz, m_rv;
  bit [7:0]  m_sel [4];
  bit [31:0] m_cnt [4];
  bit [31:0] m_rd;

  function automatic bit m_hit(int k);
    int c = int'(m_sel[k]);
    if (c >= EVT_W) return 1'b0;
    if (c == 'h41 || c == 'h42) return evt_pulse[c] && id_match[k-1];
    return evt_pulse[c];
  endfunction

  function automatic bit [31:0] m_read(int a);
    if (a == 0) return {31'b0, m_run};
    if (a == 1) return {31'b0, m_frz};
    if (a >= 2 && a <= 5) return {24'b0, m_sel[a-2]};
    if (a >= 8 && a <= 11) return m_cnt[a-8];
    return 32'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_frz = 0; m_rv = 0; m_rd = 0;
      for (int k = 0; k < 4; k++) begin m_sel[k] = 0; m_cnt[k] = 0; end
    end else begin
      bit        go;
      bit        set_f;
      bit        clr_f;
      bit [31:0] nc [4];
      go = m_run && !m_frz;
      set_f = 0;
      m_rv = reg_rd_en;
      if (reg_rd_en) m_rd = m_read(int'(reg_rd_addr));
      for (int k = 0; k < 4; k++) nc[k] = m_cnt[k];
      if (go) begin
        if (m_cnt[0] == 32'hFFFF_FFFF) set_f = 1; else nc[0] = m_cnt[0] + 1;
        for (int k = 1; k < 4; k++) if (m_hit(k)) nc[k] = m_cnt[k] + 1;
      end
      clr_f = reg_wr_en && reg_wr_addr == 1 && reg_wr_data[0];
      if (reg_wr_en) begin
        if (reg_wr_addr >= 2 && reg_wr_addr <= 5) m_sel[reg_wr_addr-2] = reg_wr_data[7:0];
        if (reg_wr_addr >= 8 && reg_wr_addr <= 11 && !m_run) nc[reg_wr_addr-8] = reg_wr_data;
        if (reg_wr_addr == 0) m_run = reg_wr_data[0];
      end
      for (int k = 0; k < 4; k++) m_cnt[k] = nc[k];
      m_frz = set_f || (m_frz && !clr_f);
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check({tag, " irq (R4/R8)"}, {31'b0, irq}, {31'b0, m_frz});
      check({tag, " rd_valid (R2)"}, {31'b0, reg_rd_valid}, {31'b0, m_rv});
      check({tag, " rd_data (R10)"}, reg_rd_data, m_rd);
    end
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic cyc(int n, bit rnd);
    for (int i = 0; i < n; i++) begin
      if (rnd) begin
        evt_pulse = {$urandom, $urandom, $urandom, $urandom};
        id_match  = 3'($urandom);
      end else begin
        evt_pulse = '0;
      end
      @(negedge clk);
    end
    evt_pulse = '0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_wr_en = 1; reg_wr_addr = 4'(a); reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(int a);
    reg_rd_en = 1; reg_rd_addr = 4'(a);
    @(negedge clk);
    reg_rd_en = 0;
  endtask

  task automatic read_all();
    for (int a = 0; a < 12; a++) rd(a);
    cyc(1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 irq in reset", {31'b0, irq}, 32'b0);
    check("R1 rd_valid in reset", {31'b0, reg_rd_valid}, 32'b0);
    check("R1 rd_data in reset", reg_rd_data, 32'b0);
    rst_n = 1;
    @(negedge clk);
    tag = "R1"; read_all();

    tag = "R2";
    wr(2, 32'h0000_00A5); wr(3, 32'h0000_0105); wr(4, 32'h41); wr(5, 32'h42);
    wr(0, 1); read_all(); rd(6); rd(15); cyc(1, 0);
    wr(0, 0);

    tag = "R9";
    wr(8, 0); wr(9, 0); wr(10, 0); wr(11, 0); read_all();

    tag = "R3";
    wr(0, 1); cyc(20, 0); rd(8); rd(8); cyc(2, 0);

    tag = "R5";
    cyc(200, 1); rd(9); rd(10); rd(11); cyc(1, 0);
    for (int i = 0; i < 10; i++) begin cyc(13, 1); rd(8 + (i % 4)); end
    wr(0, 0); wr(9, 32'hFFFF_FFFD); wr(0, 1);
    evt_pulse = '0; evt_pulse[5] = 1;
    for (int i = 0; i < 5; i++) begin @(negedge clk); rd(9); end
    evt_pulse = '0; cyc(2, 0);

    tag = "R6";
    wr(3, 32'h42);
    for (int i = 0; i < 40; i++) begin
      evt_pulse = '0; evt_pulse[8'h41] = i[0]; evt_pulse[8'h42] = i[1];
      id_match = 3'(i >> 2);
      @(negedge clk);
    end
    evt_pulse = '0; rd(9); rd(10); rd(11); cyc(1, 0);

    tag = "R7";
    wr(3, 32'hC8); wr(4, 32'h80); rd(9); rd(10);
    evt_pulse = '1; id_match = '1; cyc(0, 0);
    for (int i = 0; i < 10; i++) @(negedge clk);
    evt_pulse = '0; rd(9); rd(10); cyc(1, 0);

    tag = "R9";
    wr(9, 32'h1234_5678); wr(8, 0); rd(9); rd(8); cyc(1, 0);

    tag = "R4";
    wr(3, 32'h05); wr(0, 0); wr(8, 32'hFFFF_FFF0); wr(0, 1);
    cyc(30, 1); read_all(); cyc(20, 1); read_all();

    tag = "R8";
    wr(1, 0); cyc(3, 0); rd(1);
    wr(1, 1); cyc(3, 0); rd(1); rd(8);
    wr(0, 0); wr(1, 1); wr(8, 32'hFFFF_FFFC); wr(0, 1);
    for (int i = 0; i < 8; i++) wr(1, 1);
    rd(1); cyc(2, 0);
    wr(0, 0); wr(1, 1); wr(8, 0); wr(0, 1); cyc(10, 1); read_all();

    tag = "R10";
    rd(11); cyc(15, 1); rd(8); cyc(10, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule